// File: doc/BRIEF.md
# Vendor DMA Setup Request Decoder

This block watches the byte stream of a USB control endpoint and picks out one vendor write request that asks the device to arm a DMA transfer. A setup-start marker opens an 8-byte setup packet. If every setup byte carries the expected signature, the block gathers a 6-byte data stage. From that data stage it extracts a 24-bit start address, a 16-bit transfer size, a start flag and a token direction.

A complete and valid request with the start flag set produces a one-cycle request strobe. The decoded fields are held on registered outputs. A setup packet that does not carry the signature produces a one-cycle stall pulse, and its data stage is dropped. Token decoding, CRC checks and the handshake reply are handled elsewhere. The block only classifies and extracts.

Top module: `vdma_setup_decoder`

## Requirements
- R1: A setup packet matches only if its eight bytes, in arrival order, are 0x40, 0x0C, 0x00, 0x00, 0x71, 0x04, 0x06, 0x00. These are the request type, the request code, the value field low then high, the index 0x0471 low byte first, and the length 6 low byte first.
- R2: In a matched request, data bytes 0, 1 and 2 become `req_addr` bits 7:0, 15:8 and 23:16.
- R3: In a matched request, data bytes 3 and 4 become `req_size` bits 7:0 and 15:8.
- R4: If any of the eight setup bytes differs from R1, `stall` is high for exactly the one cycle after the eighth setup byte is accepted. The following data bytes give no request and leave the fields unchanged.
- R5: Data byte 5 is the command. A request is issued only when its bit 7 is 1. Its bit 0 drives `req_in` (1 = IN, 0 = OUT). With bit 7 clear, the bytes are consumed and the outputs stay unchanged.
- R6: `req_valid` is high for exactly the one cycle after the sixth data byte is accepted, and the new field values appear in that same cycle.
- R7: `setup_start` restarts decoding at any point and discards any partial setup or data stage. When it comes with `byte_valid`, that byte is setup byte 0. When it comes alone, the next valid byte is setup byte 0. Bytes that arrive before any marker are ignored.
- R8: If fewer than six data bytes arrive before the next marker, there is no request and no stall. Data bytes beyond the sixth have no effect.
- R9: After reset, all outputs are 0. `req_addr`, `req_size` and `req_in` change only in a cycle where `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | `byte_data` carries a byte this cycle |
| byte_data | input | 8 | Endpoint byte |
| setup_start | input | 1 | Start of a new setup packet |
| req_valid | output | 1 | One-cycle strobe for an accepted DMA request |
| req_addr | output | 24 | Start address of the last request |
| req_size | output | 16 | Transfer size of the last request |
| req_in | output | 1 | Direction of the last request (1 = IN) |
| stall | output | 1 | One-cycle pulse for a non-matching setup packet |

## Verification
The bench corrupts each of the eight setup bytes in turn. A design that skipped one field compare would issue a request where a stall is due. It also truncates data stages and then restarts them with a marker, which catches a design that issues a request for leftover bytes. It sends extra data bytes, which catches a design that strobes a second time. Requests with the start bit clear check that an unarmed command neither strobes nor disturbs the held fields. Markers sent with and without a byte mid-packet check that a restart realigns byte 0 instead of shifting all later fields by one position.

// File: rtl/vdma_setup_decoder.sv
module vdma_setup_decoder #(
  parameter logic [7:0]  REQ_TYPE   = 8'h40,
  parameter logic [7:0]  REQ_CODE   = 8'h0C,
  parameter logic [15:0] REQ_INDEX  = 16'h0471,
  parameter int          ADDR_BYTES = 3,
  parameter int          SIZE_BYTES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      byte_valid,
  input  logic [7:0]                byte_data,
  input  logic                      setup_start,
  output logic                      req_valid,
  output logic [8*ADDR_BYTES-1:0]   req_addr,
  output logic [8*SIZE_BYTES-1:0]   req_size,
  output logic                      req_in,
  output logic                      stall
);
  localparam int ADDR_W   = 8 * ADDR_BYTES;
  localparam int SIZE_W   = 8 * SIZE_BYTES;
  localparam int DATA_LEN = ADDR_BYTES + SIZE_BYTES + 1;
  localparam int HOLD_W   = 8 * (DATA_LEN - 1);
  localparam int DCNT_W   = $clog2(DATA_LEN + 1);
  localparam logic [15:0] LEN16 = 16'(DATA_LEN);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_DATA, PH_DONE} phase_t;

  phase_t              phase;
  logic [2:0]          scnt;
  logic [DCNT_W-1:0]   dcnt;
  logic                match_q;
  logic [HOLD_W-1:0]   hold;
  logic [8*DATA_LEN-1:0] frame;
  logic                byte_ok;

  function automatic logic [7:0] sig_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return REQ_TYPE;
      3'd1:    return REQ_CODE;
      3'd4:    return REQ_INDEX[7:0];
      3'd5:    return REQ_INDEX[15:8];
      3'd6:    return LEN16[7:0];
      3'd7:    return LEN16[15:8];
      default: return 8'h00;
    endcase
  endfunction

  assign byte_ok = (byte_data == sig_byte(scnt));
  assign frame   = {byte_data, hold};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      scnt      <= '0;
      dcnt      <= '0;
      match_q   <= 1'b1;
      hold      <= '0;
      req_valid <= 1'b0;
      stall     <= 1'b0;
      req_addr  <= '0;
      req_size  <= '0;
      req_in    <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      stall     <= 1'b0;
      if (setup_start) begin
        phase   <= PH_SETUP;
        dcnt    <= '0;
        if (byte_valid) begin
          scnt    <= 3'd1;
          match_q <= (byte_data == sig_byte(3'd0));
        end else begin
          scnt    <= 3'd0;
          match_q <= 1'b1;
        end
      end else if (byte_valid) begin
        case (phase)
          PH_SETUP: begin
            if (scnt == 3'd7) begin
              if (match_q && byte_ok) begin
                phase <= PH_DATA;
                dcnt  <= '0;
              end else begin
                phase <= PH_IDLE;
                stall <= 1'b1;
              end
            end else begin
              scnt    <= scnt + 3'd1;
              match_q <= match_q && byte_ok;
            end
          end
          PH_DATA: begin
            hold <= frame[8*DATA_LEN-1:8];
            if (dcnt == DCNT_W'(DATA_LEN - 1)) begin
              phase <= PH_DONE;
              if (byte_data[7]) begin
                req_valid <= 1'b1;
                req_addr  <= frame[ADDR_W-1:0];
                req_size  <= frame[ADDR_W +: SIZE_W];
                req_in    <= byte_data[0];
              end
            end else begin
              dcnt <= dcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid); // R6
  AST_STALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R4
  AST_REQ_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && stall)); // R4
  AST_REQ_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(byte_valid && byte_data[7] && !setup_start)); // R5
  AST_STALL_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> $past(byte_valid && !setup_start)); // R4
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> $stable({req_addr, req_size, req_in})); // R9
endmodule

// File: tb/tb_vdma_setup_decoder.sv
module tb_vdma_setup_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        setup_start = 1'b0;
  logic        req_valid;
  logic [23:0] req_addr;
  logic [15:0] req_size;
  logic        req_in;
  logic        stall;

  int total = 0;
  int bad = 0;
  logic [23:0] m_addr = '0;
  logic [15:0] m_size = '0;
  logic        m_in = 1'b0;

  always #10 clk = ~clk;

  vdma_setup_decoder dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .setup_start(setup_start), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_in(req_in), .stall(stall)
  );

  function automatic logic [7:0] sig(input int i);
    logic [7:0] s [8] = '{8'h40, 8'h0C, 8'h00, 8'h00, 8'h71, 8'h04, 8'h06, 8'h00};
    return s[i];
  endfunction

  function automatic logic [7:0] data_byte(input int j, input logic [23:0] a,
                                            input logic [15:0] s, input logic [7:0] c);
    case (j)
      0: return a[7:0];
      1: return a[15:8];
      2: return a[23:16];
      3: return s[7:0];
      4: return s[15:8];
      5: return c;
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic mark);
    byte_valid  = 1'b1;
    byte_data   = b;
    setup_start = mark;
    @(negedge clk);
    byte_valid  = 1'b0;
    setup_start = 1'b0;
  endtask

  task automatic check_fields(input string req);
    check(req, {39'b0, req_addr, req_in}, {39'b0, m_addr, m_in});
    check(req, {48'b0, req_size}, {48'b0, m_size});
  endtask

  task automatic txn(input int bad_idx, input logic [7:0] flip, input int n,
                     input logic [23:0] a, input logic [15:0] s, input logic [7:0] c,
                     input logic mark0);
    logic exp_req;
    for (int i = 0; i < 8; i++) begin
      send(sig(i) ^ ((i == bad_idx) ? flip : 8'h00), mark0 && (i == 0));
      if (i == 7) check("R1/R4 stall", {63'b0, stall}, {63'b0, bad_idx >= 0});
    end
    exp_req = (bad_idx < 0) && c[7] && (n >= 6);
    for (int j = 0; j < n; j++) begin
      send(data_byte(j, a, s, c), 1'b0);
      if (j == 5) begin
        check("R5/R6 req_valid", {63'b0, req_valid}, {63'b0, exp_req});
        if (exp_req) begin
          m_addr = a; m_size = s; m_in = c[0];
        end
        check_fields("R2/R3/R5 fields");
      end else if (j > 5) begin
        check("R8 extra byte", {62'b0, req_valid, stall}, 64'd0);
      end
    end
    @(negedge clk);
    check("R6 single pulse", {62'b0, req_valid, stall}, 64'd0);
    check_fields("R9 hold");
  endtask

  initial begin
    bit done = 0;
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          bad++; total++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset", {23'b0, req_valid, stall, req_in, req_size, req_addr}, 64'd0);

    // R7: bytes before any marker are ignored
    for (int i = 0; i < 8; i++) send(sig(i), 1'b0);
    for (int j = 0; j < 6; j++) send(data_byte(j, 24'h111111, 16'h2222, 8'h81), 1'b0);
    check("R7 pre-marker", {62'b0, req_valid, stall}, 64'd0);
    check_fields("R7 pre-marker fields");

    // basic IN and OUT requests
    txn(-1, 8'h00, 6, 24'hA1B2C3, 16'hD4E5, 8'h81, 1'b1);
    txn(-1, 8'h00, 6, 24'h010203, 16'h0405, 8'h80, 1'b1);
    // R5 start bit clear
    txn(-1, 8'h00, 6, 24'hFFFFFF, 16'hFFFF, 8'h7F, 1'b1);
    // R4 each setup byte wrong
    for (int k = 0; k < 8; k++) txn(k, 8'h01 << (k % 8), 6, 24'h5A5A5A, 16'h1234, 8'h81, 1'b1);
    // R8 short data stage then fresh marker, and extra bytes
    txn(-1, 8'h00, 4, 24'h999999, 16'h8888, 8'h81, 1'b1);
    txn(-1, 8'h00, 9, 24'h0F0E0D, 16'h0C0B, 8'h81, 1'b1);
    // R7 marker with byte mid-setup
    for (int i = 0; i < 3; i++) send(sig(i), i == 0);
    txn(-1, 8'h00, 6, 24'h123456, 16'h789A, 8'h80, 1'b1);
    // R7 marker alone mid-data, next byte is setup byte 0
    for (int i = 0; i < 8; i++) send(sig(i), i == 0);
    send(8'hEE, 1'b0); send(8'hEE, 1'b0);
    setup_start = 1'b1; @(negedge clk); setup_start = 1'b0;
    check("R7 marker alone", {62'b0, req_valid, stall}, 64'd0);
    txn(-1, 8'h00, 6, 24'hCAFE01, 16'h0BAD, 8'h81, 1'b0);

    // constrained random
    for (int t = 0; t < 400; t++) begin
      int bi;
      int n;
      bi = ($urandom % 4 == 0) ? int'($urandom % 8) : -1;
      n  = ($urandom % 5 == 0) ? int'($urandom % 9) : 6;
      txn(bi, 8'h01 << ($urandom % 8), n, 24'($urandom), 16'($urandom),
          8'($urandom) | (($urandom % 4 != 0) ? 8'h80 : 8'h00), 1'b1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule